// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a free-running timer. It takes the counter value from outside and works in one of two modes. In capture mode it watches an external pin and stores the counter value when the chosen edge arrives. In compare mode it signals when the counter reaches a programmed 16-bit value, and it can toggle an output pin. An 8-bit control/status register holds the event flag, the interrupt enable, the mode, the edge selection and the toggle control. A CPU reads and writes this register through simple strobes.

The event flag clears only through a two-step handshake. First a read must see the flag at one, which arms the clear. Then a write with a zero in the flag position clears it. Any capture or compare event that lands after the arming read cancels the arming, so a pending event can never be erased by mistake. The interrupt request is the event flag gated by the enable bit.

Top module: `tmr_chan`

## Requirements
- R1: After reset the control register reads 8'h00, and `irq`, `pin_out` and `val_q` are all zero.
- R2: A control write loads bits 6:0 from `wdata` on the next clock edge. Writing one to bit 7 (the event flag) never sets it.
- R3: In capture mode, the edge field (bits 3:2) selects the active edge: 00 none, 01 rising, 10 falling, 11 both. `pin_in` passes through a two-flop synchronizer, so the flag sets on the third rising clock edge after the pin changes.
- R4: On a capture event, `val_q` takes the `cnt_val` value present at the clock edge that sets the flag.
- R5: In compare mode, the flag sets on the clock edge where `cnt_val` first equals `val_q`.
- R6: The flag clears only after an arming sequence: a `reg_rd` cycle while the flag is one, then a `reg_wr` with `wdata[7]`=0 and no event in between.
- R7: A zero write to bit 7 with no arming read before it leaves the flag set.
- R8: An event after the arming read, or in the same cycle as the zero write, cancels the arming, and the flag stays set.
- R9: `irq` is high exactly while both the flag (bit 7) and the enable (bit 6) are one.
- R10: In compare mode with the toggle bit (bit 1) set, `pin_out` inverts on each compare match and on each `cnt_ovf` pulse. With bit 1 clear, `pin_out` holds.
- R11: The mode field (bits 5:4) selects capture when it is 00 and compare otherwise. In compare mode, pin edges raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Free-running counter value |
| cnt_ovf | input | 1 | One-cycle pulse on counter wrap |
| pin_in | input | 1 | Channel input pin (asynchronous) |
| reg_rd | input | 1 | Read strobe for the control register |
| reg_wr | input | 1 | Write strobe for the control register |
| wdata | input | 8 | Control register write data |
| rdata | output | 8 | Control register contents |
| val_wr | input | 1 | Write strobe for the channel value |
| val_wdata | input | 16 | Channel value write data |
| val_q | output | 16 | Channel value (compare target or captured count) |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the arming state is wrong. Then the very next zero write shows it in `rdata[7]` and `irq`: the flag either clears when it should hold, or holds when it should clear. A broken edge decode or synchronizer shows up three cycles after a pin change, as a flag that is missing, extra or late. A broken compare or toggle path shows up on `rdata[7]` or `pin_out` one cycle after the matching count is presented.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  // control/status register layout, MSB first
  typedef struct packed {
    logic       flag;   // bit 7 event flag
    logic       ie;     // bit 6 interrupt enable
    logic [1:0] ms;     // bits 5:4 mode select
    logic [1:0] els;    // bits 3:2 edge select
    logic       tov;    // bit 1 toggle control
    logic       maxd;   // bit 0 max-duty control (stored only)
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam logic [1:0] EDGE_NONE = 2'b00;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       en,
  input  logic [1:0] els,
  output logic       edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;
  logic              cur;
  logic              rise;
  logic              fall;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b0;
          else     sh_q[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[i] <= 1'b0;
          else     sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  assign cur = sh_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= cur;
  end

  assign rise   = cur & ~last_q;
  assign fall   = ~cur & last_q;
  assign edge_o = en & ((els[0] & rise) | (els[1] & fall));

  // R3: no edge reported when detection is disabled or no edge selected
  edge_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!en || els == 2'b00) |-> !edge_o);
endmodule

// File: rtl/tmr_cmp_cap.sv
module tmr_cmp_cap #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          cmp_mode,
  input  logic          tov,
  input  logic          cap_evt,
  input  logic          val_wr,
  input  logic [CW-1:0] val_wdata,
  output logic [CW-1:0] val_q,
  output logic          cmp_evt,
  output logic          pin_out
);
  logic match;
  logic match_d;
  logic do_tog;

  assign match   = (cnt_val == val_q);
  assign cmp_evt = cmp_mode & match & ~match_d;
  assign do_tog  = cmp_mode & tov & (cmp_evt | cnt_ovf);

  always_ff @(posedge clk) begin
    if (rst) match_d <= 1'b0;
    else     match_d <= match;
  end

  // capture has priority over a CPU write in the same cycle
  always_ff @(posedge clk) begin
    if (rst)          val_q <= '0;
    else if (cap_evt) val_q <= cnt_val;
    else if (val_wr)  val_q <= val_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         pin_out <= 1'b0;
    else if (do_tog) pin_out <= ~pin_out;
  end

  // R4
  cap_latch_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (val_q == $past(cnt_val)));

  // R10
  pin_tog_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_out) |-> $past(cmp_mode && tov && (cmp_evt || cnt_ovf)));
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             evt,
  output ctl_t             ctl
);
  logic armed_q;
  ctl_t wr_view;

  assign wr_view = ctl_t'(wdata);

  // writable bits: everything but the flag
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl.ie   <= 1'b0;
      ctl.ms   <= 2'b00;
      ctl.els  <= EDGE_NONE;
      ctl.tov  <= 1'b0;
      ctl.maxd <= 1'b0;
    end else if (wr) begin
      ctl.ie   <= wr_view.ie;
      ctl.ms   <= wr_view.ms;
      ctl.els  <= wr_view.els;
      ctl.tov  <= wr_view.tov;
      ctl.maxd <= wr_view.maxd;
    end
  end

  // flag and arming handshake; events win over everything
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl.flag <= 1'b0;
      armed_q  <= 1'b0;
    end else if (evt) begin
      ctl.flag <= 1'b1;
      armed_q  <= 1'b0;
    end else if (wr) begin
      if (armed_q && !wr_view.flag) ctl.flag <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd && ctl.flag) begin
      armed_q <= 1'b1;
    end
  end

  // R2
  wr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> (ctl[CTL_W-2:0] == $past(wdata[CTL_W-2:0])));

  // R8
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> ctl.flag);

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.flag) |-> $past(evt));

  // R6
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl.flag) |-> $past(wr && !wdata[CTL_W-1] && !evt));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_ovf,
  input  logic          pin_in,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          val_wr,
  input  logic [CW-1:0] val_wdata,
  output logic [CW-1:0] val_q,
  output logic          pin_out,
  output logic          irq
);
  ctl_t ctl;
  logic cmp_mode;
  logic cap_evt;
  logic cmp_evt;
  logic evt;

  assign cmp_mode = |ctl.ms;
  assign evt      = cap_evt | cmp_evt;

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .en     (~cmp_mode),
    .els    (ctl.els),
    .edge_o (cap_evt)
  );

  tmr_cmp_cap #(.CW(CW)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .cnt_ovf   (cnt_ovf),
    .cmp_mode  (cmp_mode),
    .tov       (ctl.tov),
    .cap_evt   (cap_evt),
    .val_wr    (val_wr),
    .val_wdata (val_wdata),
    .val_q     (val_q),
    .cmp_evt   (cmp_evt),
    .pin_out   (pin_out)
  );

  tmr_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .wr    (reg_wr),
    .wdata (wdata),
    .evt   (evt),
    .ctl   (ctl)
  );

  assign rdata = ctl;
  assign irq   = ctl.flag & ctl.ie;

  // R11
  mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cap_evt && cmp_evt));

  // R9
  irq_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rdata[7] && rdata[6]));
endmodule

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cnt_val = 16'hFFFF;
  logic        cnt_ovf = 1'b0;
  logic        pin_in = 1'b0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        val_wr = 1'b0;
  logic [15:0] val_wdata = 16'h0000;
  logic [15:0] val_q;
  logic        pin_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr_chan u0 (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
    .pin_in(pin_in), .reg_rd(reg_rd), .reg_wr(reg_wr), .wdata(wdata),
    .rdata(rdata), .val_wr(val_wr), .val_wdata(val_wdata), .val_q(val_q),
    .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [7:0] d);
    reg_wr = 1'b1; wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic ctl_read();
    reg_rd = 1'b1;
    tick(1);
    reg_rd = 1'b0;
  endtask

  task automatic val_write(input logic [15:0] d);
    val_wr = 1'b1; val_wdata = d;
    tick(1);
    val_wr = 1'b0;
  endtask

  task automatic clear_flag(input logic [7:0] keep);
    ctl_read();
    ctl_write(keep & 8'h7F);
  endtask

  task automatic set_pin(input logic v);
    pin_in = v;
    tick(4);
  endtask

  task automatic t_reset();
    check("R1 ctl", rdata, 8'h00);
    check("R1 irq", irq, 1'b0);
    check("R1 pin_out", pin_out, 1'b0);
    check("R1 val_q", val_q, 16'h0000);
  endtask

  task automatic t_bits();
    ctl_write(8'h7D);
    check("R2 write bits", rdata, 8'h7D);
    ctl_write(8'hFC);
    check("R2 flag write one ignored", rdata, 8'h7C);
    ctl_write(8'h00);
    check("R2 write zero", rdata, 8'h00);
  endtask

  task automatic t_capture();
    cnt_val = 16'h1234;
    ctl_write(8'h44);             // capture, rising, ie
    pin_in = 1'b1;
    tick(2);
    check("R3 not before third edge", rdata[7], 1'b0);
    tick(1);
    check("R3 rising sets flag", rdata[7], 1'b1);
    check("R4 captured value", val_q, 16'h1234);
    check("R9 irq with ie", irq, 1'b1);
    clear_flag(8'h44);
    check("R6 handshake clears", rdata[7], 1'b0);
    check("R9 irq drops", irq, 1'b0);
    cnt_val = 16'h2222;
    set_pin(1'b0);
    check("R3 falling ignored on rising select", rdata[7], 1'b0);
    check("R4 value kept", val_q, 16'h1234);
    ctl_write(8'h08);             // falling only, ie off
    set_pin(1'b1);
    check("R3 rising ignored on falling select", rdata[7], 1'b0);
    set_pin(1'b0);
    check("R3 falling sets flag", rdata[7], 1'b1);
    check("R4 value on falling", val_q, 16'h2222);
    check("R9 no irq without ie", irq, 1'b0);
    clear_flag(8'h0C);            // now both edges
    set_pin(1'b1);
    check("R3 both: rising", rdata[7], 1'b1);
    clear_flag(8'h0C);
    set_pin(1'b0);
    check("R3 both: falling", rdata[7], 1'b1);
    clear_flag(8'h00);            // edge select none
    set_pin(1'b1);
    set_pin(1'b0);
    check("R3 none selected", rdata[7], 1'b0);
  endtask

  task automatic t_no_arm();
    ctl_write(8'h04);
    set_pin(1'b1);
    check("R7 setup flag", rdata[7], 1'b1);
    ctl_write(8'h04);
    check("R7 write without read keeps flag", rdata[7], 1'b1);
    clear_flag(8'h04);
    check("R6 clear after arming", rdata[7], 1'b0);
    set_pin(1'b0);
  endtask

  task automatic t_compare();
    cnt_val = 16'h0010;
    val_write(16'h0050);
    ctl_write(8'h10);             // compare mode, no toggle
    set_pin(1'b1);
    check("R11 pin edge ignored in compare", rdata[7], 1'b0);
    cnt_val = 16'h004F;
    tick(1);
    check("R5 no flag before match", rdata[7], 1'b0);
    cnt_val = 16'h0050;
    tick(1);
    check("R5 match sets flag", rdata[7], 1'b1);
    check("R10 no toggle when bit clear", pin_out, 1'b0);
    cnt_val = 16'h0051;
    // event between arming read and zero write
    ctl_read();
    cnt_val = 16'h0050;
    tick(1);
    cnt_val = 16'h0052;
    ctl_write(8'h10);
    check("R8 event after arm keeps flag", rdata[7], 1'b1);
    // event in the same cycle as the zero write
    ctl_read();
    reg_wr = 1'b1; wdata = 8'h10; cnt_val = 16'h0050;
    tick(1);
    reg_wr = 1'b0; cnt_val = 16'h0053;
    check("R8 same-cycle event keeps flag", rdata[7], 1'b1);
    clear_flag(8'h10);
    check("R6 clears after clean handshake", rdata[7], 1'b0);
    cnt_ovf = 1'b1;
    tick(1);
    cnt_ovf = 1'b0;
    check("R10 overflow no toggle when bit clear", pin_out, 1'b0);
  endtask

  task automatic t_toggle();
    ctl_write(8'h22);             // compare via upper mode bit, toggle on
    cnt_val = 16'h0050;
    tick(1);
    check("R10 toggle on match", pin_out, 1'b1);
    check("R11 upper mode bit is compare", rdata[7], 1'b1);
    cnt_val = 16'h0054;
    cnt_ovf = 1'b1;
    tick(1);
    cnt_ovf = 1'b0;
    check("R10 toggle on overflow", pin_out, 1'b0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_bits();
    t_capture();
    t_no_arm();
    t_compare();
    t_toggle();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule